// File: doc/BRIEF.md
# Caller-ID Data Stream Qualifier

This block sits behind an FSK demodulator on the receive side of a caller-ID path. It takes the recovered bit with a one-cycle strobe per bit, plus a carrier-present flag and an enable. It drives a single serial line that stays at mark (logic 1) until the incoming stream has shown a valid lead-in. The lead-in is a long run of alternating 1/0 bits (the channel seizure), followed by a sustained run of mark bits. After that, the recovered bits are copied to the line one per strobe. The seizure pattern itself never reaches the line.

The controller has four states. IDLE waits for the first strobe while the block is active, meaning enable and carrier are both high. SEIZURE counts the length of the current alternating run. MARK counts consecutive 1 bits. PASS forwards data.

The transitions are as follows:
- IDLE goes to SEIZURE on any strobe while active.
- SEIZURE goes to MARK when a repeated 1 arrives after at least `SEIZE_MIN` alternating bits.
- MARK goes to PASS when the run of consecutive 1s, counted from the last alternating 1, reaches `MARK_MIN`.
- MARK falls back to SEIZURE on a 0 that arrives before that count is reached.
- Every state returns to IDLE as soon as carrier or enable drops.

Byte framing and checksums belong downstream.

Top module: `cid_qualifier`

## Requirements
- R1: While reset is asserted and after its release, `data_out` is 1, and the controller is in IDLE.
- R2: In IDLE, SEIZURE and MARK, `data_out` is 1 whatever `bit_in` carries, so no bit of the alternating lead-in ever appears on the line.
- R3: A repeated 1 that follows an alternating run of at least `SEIZE_MIN` (default 32) bits moves SEIZURE to MARK. The same repeated 1 after a shorter run does not.
- R4: Any repeated bit in SEIZURE restarts the alternating run count at 1. A full `SEIZE_MIN` run must then be seen again.
- R5: MARK moves to PASS on the strobe where the count of consecutive 1s reaches `MARK_MIN` (default 16). That count includes the final alternating 1. A 0 received in MARK before the count is reached returns the controller to SEIZURE.
- R6: In PASS, each strobe copies `bit_in` to `data_out` one clock after the strobe edge. Between strobes, `data_out` holds its value.
- R7: Carrier low sends the controller to IDLE and forces `data_out` to 1 on the next clock. Afterwards, the full lead-in is needed again.
- R8: Enable low acts like loss of carrier, and strobes received while it is low are ignored.
- R9: A repeated 0 after a complete alternating run does not enter MARK. It only restarts the run count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable, high to operate |
| carrier | input | 1 | Carrier-present flag from the demodulator |
| bit_stb | input | 1 | One-cycle strobe marking a valid `bit_in` |
| bit_in | input | 1 | Demodulated bit, 1 = mark |
| data_out | output | 1 | Qualified serial data, idles at 1 |

## Verification
A controller stuck outside PASS shows only as a line that never leaves mark. A controller that enters PASS early leaks zeros of the preamble within one bit time. The bench therefore drives lead-ins of exact length at and one bit below each threshold, ending on either bit value, and then sends a data pattern whose first bit is 0. The first data bit reveals on the next clock whether qualification happened. Wrong run counting after a break, or a missed reset on carrier or enable loss, shows in the same way on the first 0 bit after the stimulus.

// File: rtl/cidq_pkg.sv
package cidq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEIZURE = 2'd1,
        ST_MARK    = 2'd2,
        ST_PASS    = 2'd3
    } cidq_state_e;
endpackage

// File: rtl/cidq_run_tracker.sv
module cidq_run_tracker #(
    parameter int SEIZE_MIN = 32,
    parameter int MARK_MIN  = 16,
    localparam int AW = $clog2(SEIZE_MIN + 1),
    localparam int MW = $clog2(MARK_MIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          bit_stb,
    input  logic          bit_in,
    output logic          have_last,
    output logic          last_bit,
    output logic [AW-1:0] alt_cnt,
    output logic [MW-1:0] ones_cnt
);
    localparam logic [AW-1:0] ALT_TOP  = AW'(SEIZE_MIN);
    localparam logic [MW-1:0] ONES_TOP = MW'(MARK_MIN);

    // Alternating-run length and consecutive-ones length, both saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_bit  <= 1'b1;
            alt_cnt   <= '0;
            ones_cnt  <= '0;
        end else if (!active) begin
            have_last <= 1'b0;
            last_bit  <= 1'b1;
            alt_cnt   <= '0;
            ones_cnt  <= '0;
        end else if (bit_stb) begin
            have_last <= 1'b1;
            last_bit  <= bit_in;
            if (!have_last || bit_in == last_bit)
                alt_cnt <= AW'(1);
            else if (alt_cnt != ALT_TOP)
                alt_cnt <= alt_cnt + 1'b1;
            if (!bit_in)
                ones_cnt <= '0;
            else if (ones_cnt != ONES_TOP)
                ones_cnt <= ones_cnt + 1'b1;
        end
    end

    assert_alt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alt_cnt <= ALT_TOP);

    assert_repeat_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_stb && have_last && bit_in == last_bit) |=> alt_cnt == AW'(1));

    assert_zero_clears_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_stb && !bit_in) |=> ones_cnt == '0);
endmodule

// File: rtl/cidq_fsm.sv
module cidq_fsm
    import cidq_pkg::*;
#(
    parameter int SEIZE_MIN = 32,
    parameter int MARK_MIN  = 16,
    localparam int AW = $clog2(SEIZE_MIN + 1),
    localparam int MW = $clog2(MARK_MIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          bit_stb,
    input  logic          bit_in,
    input  logic          have_last,
    input  logic          last_bit,
    input  logic [AW-1:0] alt_cnt,
    input  logic [MW-1:0] ones_cnt,
    output cidq_state_e   state,
    output logic          data_out
);
    localparam logic [AW-1:0] ALT_TOP   = AW'(SEIZE_MIN);
    localparam logic [MW-1:0] ONES_LAST = MW'(MARK_MIN - 1);

    cidq_state_e state_nx;
    logic        armed_repeat;
    logic        mark_done;

    assign armed_repeat = have_last && bit_in && last_bit && (alt_cnt == ALT_TOP);
    assign mark_done    = bit_in && (ones_cnt >= ONES_LAST);

    always_comb begin
        state_nx = state;
        if (!active) begin
            state_nx = ST_IDLE;
        end else if (bit_stb) begin
            unique case (state)
                ST_IDLE:    state_nx = ST_SEIZURE;
                ST_SEIZURE: if (armed_repeat) state_nx = ST_MARK;
                ST_MARK: begin
                    if (!bit_in)        state_nx = ST_SEIZURE;
                    else if (mark_done) state_nx = ST_PASS;
                end
                ST_PASS:    state_nx = ST_PASS;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 data_out <= 1'b1;
        else if (!active)           data_out <= 1'b1;
        else if (state != ST_PASS)  data_out <= 1'b1;
        else if (bit_stb)           data_out <= bit_in;
    end

    assert_high_unless_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PASS) |=> data_out);

    assert_mark_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK && $past(state) == ST_SEIZURE) |-> $past(alt_cnt) == ALT_TOP);

    assert_pass_needs_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && $past(state) != ST_PASS) |-> ones_cnt >= MW'(MARK_MIN));

    assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_stb && state == ST_PASS) |=> data_out == $past(bit_in));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_stb && state == ST_PASS) |=> $stable(data_out));

    assert_inactive_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == ST_IDLE && data_out));
endmodule

// File: rtl/cid_qualifier.sv
module cid_qualifier
    import cidq_pkg::*;
#(
    parameter int SEIZE_MIN = 32,
    parameter int MARK_MIN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic carrier,
    input  logic bit_stb,
    input  logic bit_in,
    output logic data_out
);
    localparam int AW = $clog2(SEIZE_MIN + 1);
    localparam int MW = $clog2(MARK_MIN + 1);

    logic          active;
    logic          have_last;
    logic          last_bit;
    logic [AW-1:0] alt_cnt;
    logic [MW-1:0] ones_cnt;
    cidq_state_e   state;

    assign active = enable && carrier;

    cidq_run_tracker #(.SEIZE_MIN(SEIZE_MIN), .MARK_MIN(MARK_MIN)) u_track (
        .clk(clk), .rst_n(rst_n), .active(active), .bit_stb(bit_stb), .bit_in(bit_in),
        .have_last(have_last), .last_bit(last_bit), .alt_cnt(alt_cnt), .ones_cnt(ones_cnt)
    );

    cidq_fsm #(.SEIZE_MIN(SEIZE_MIN), .MARK_MIN(MARK_MIN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .bit_stb(bit_stb), .bit_in(bit_in),
        .have_last(have_last), .last_bit(last_bit), .alt_cnt(alt_cnt), .ones_cnt(ones_cnt),
        .state(state), .data_out(data_out)
    );

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == ST_IDLE && data_out));

    assert_enable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> data_out);
endmodule

// File: tb/tb_cid_qualifier.sv
module tb_cid_qualifier;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic carrier = 1'b0;
    logic bit_stb = 1'b0;
    logic bit_in = 1'b1;
    logic data_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cid_qualifier dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .carrier(carrier),
        .bit_stb(bit_stb), .bit_in(bit_in), .data_out(data_out)
    );

    // {expect_pass[15], first_bit[14], alt_len[13:7], mark_len[6:0]}
    localparam logic [15:0] SCEN [7] = '{
        {1'b1, 1'b0, 7'd32, 7'd15},
        {1'b0, 1'b0, 7'd32, 7'd14},
        {1'b0, 1'b1, 7'd31, 7'd20},
        {1'b1, 1'b0, 7'd31, 7'd16},
        {1'b1, 1'b1, 7'd40, 7'd16},
        {1'b0, 1'b1, 7'd32, 7'd15},
        {1'b1, 1'b0, 7'd64, 7'd20}
    };
    localparam logic [7:0] DATA = 8'h3C; // sent LSB first: 0,0,1,1,1,1,0,0

    task automatic chk(input logic exp, input string tag);
        n_chk++;
        if (data_out !== exp) begin
            n_bad++;
            $display("FAIL %s: data_out=%b expected=%b", tag, data_out, exp);
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    // alternating run of len bits starting with s, then m ones; line must stay high (R2)
    task automatic lead_in(input logic s, input int len, input int m);
        logic b;
        b = s;
        for (int i = 0; i < len; i++) begin
            send(b);
            chk(1'b1, "R2 preamble");
            b = ~b;
        end
        for (int i = 0; i < m; i++) begin
            send(1'b1);
            chk(1'b1, "R2 mark run");
        end
    endtask

    task automatic drop_carrier;
        @(negedge clk);
        carrier = 1'b0;
        @(negedge clk);
        chk(1'b1, "R7 carrier lost");
        carrier = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(1'b1, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b1, "R1 after reset");
        enable  = 1'b1;
        carrier = 1'b1;

        for (int k = 0; k < 7; k++) begin
            lead_in(SCEN[k][14], int'(SCEN[k][13:7]), int'(SCEN[k][6:0]));
            for (int j = 0; j < 8; j++) begin
                send(DATA[j]);
                chk(SCEN[k][15] ? DATA[j] : 1'b1, SCEN[k][15] ? "R5 R6 data" : "R3 R5 gated");
            end
            drop_carrier();
        end

        // R4: break at 20, then only 31 alternating bits: no qualification
        lead_in(1'b0, 20, 0);
        send(1'b1);
        lead_in(1'b0, 30, 20);
        send(1'b0);
        chk(1'b1, "R4 run restarted");
        drop_carrier();

        // R9: full run ending in 0, then a repeated 0
        lead_in(1'b1, 32, 0);
        send(1'b0);
        lead_in(1'b1, 0, 20);
        send(1'b0);
        chk(1'b1, "R9 repeated space");
        drop_carrier();

        // R6 hold, then R7 requalify
        lead_in(1'b0, 32, 15);
        send(1'b0);
        chk(1'b0, "R6 forward");
        repeat (6) @(negedge clk);
        chk(1'b0, "R6 hold");
        drop_carrier();
        send(1'b0);
        chk(1'b1, "R7 requalify");
        drop_carrier();

        // R8: enable low
        lead_in(1'b0, 32, 15);
        send(1'b0);
        chk(1'b0, "R6 forward");
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(1'b1, "R8 disabled");
        send(1'b0);
        chk(1'b1, "R8 strobe ignored");
        enable = 1'b1;
        send(1'b0);
        chk(1'b1, "R8 requalify");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: data_out=%b expected=end of run", data_out);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule